// File: doc/BRIEF.md
# Per-processor interrupt interface

This block is the part of a multiprocessor interrupt controller that belongs to one processor. Software reaches it through a small word-addressed register window. Through that window it turns the interface on, picks a trigger mode for each interrupt line, and enables or disables lines one at a time by writing a line number. It fetches the next interrupt to service by reading one register, and it ends service by writing the same number back. The block samples its interrupt inputs and turns level or edge activity into pending state. It offers the lowest-numbered pending, enabled and not-yet-active line to the processor. It also asserts a request output while such a line exists.

A read of the ready register claims the line it returns. The line counts as active from then on and is not offered again until it is completed. A claim clears the latched event of an edge line. A level line that is still asserted when it is completed is offered again at once. A write to the signal register sends an inter-processor interrupt toward a set of cores, carrying a short ID. An incoming inter-processor pulse pends the line reserved for that purpose.

Top module: `pirq_if`

## Requirements
- R1: After reset the control bit, every enable, every active flag and every trigger field are 0. `irq_req` and `ipi_valid` are low, and a read of the ready register (0x06C) returns the no-interrupt code, which equals NUM_IRQ (32 by default).
- R2: Bit 0 of the control register (0x000) reads back as written. While it is 0, `irq_req` stays low and a ready read returns the no-interrupt code and claims nothing.
- R3: Writing a line number to 0x0A0 enables that line only, and writing it to 0x0A4 disables it. A number of NUM_IRQ or above changes no enable.
- R4: Line n has a 2-bit trigger field at word 0x014 + 4*(n/16), bits [2*(n%16)+1 : 2*(n%16)]. A word write replaces the whole word and a read returns it. The encodings are 0 level-high, 1 level-low, 2 rising edge and 3 falling edge.
- R5: A level line follows its input through one sampling register. `irq_req` changes at the first clock edge after the input changes.
- R6: An edge line latches its event at the second clock edge after the input transition. The event stays pending after the input returns, and a claim clears it. A transition in the other direction latches nothing.
- R7: A ready read places, in `rdata` at the read edge, the lowest-numbered line that is pending, enabled and not active, and marks that line active. With no such line it returns NUM_IRQ.
- R8: Writing a line number to 0x0B4 clears that line's active flag. A level line still at its active level is offered again at once.
- R9: A write to 0x060 drives `ipi_valid` high for exactly one cycle after the write edge. `ipi_id` then carries write bits [3:0] and `ipi_mask` carries bits [8+NUM_CPU-1:8].
- R10: An `ipi_in` pulse pends line IPI_LINE (15) whatever its trigger mode or input. The pend stays until that line is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid after the read edge |
| irq_lines | input | NUM_IRQ | Interrupt inputs |
| ipi_in | input | 1 | Incoming inter-processor interrupt pulse |
| irq_req | output | 1 | A claimable interrupt exists |
| ipi_valid | output | 1 | One-cycle send pulse |
| ipi_id | output | 4 | ID of the sent inter-processor interrupt |
| ipi_mask | output | NUM_CPU | Target cores of the send |

## Verification
Register reads and the IPI send outputs are due one edge after their strobe. Level inputs reach `irq_req` one edge after they change, and edge events reach it two edges after the transition. Enable, completion and control writes act on `irq_req` at the write edge itself. The bench drives and samples at falling edges. A behavioural model updates at each rising edge and is compared with the outputs at the following falling edge. Directed checks with constant expected values are placed at exactly those offsets.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   localparam logic [11:0] OFS_CTRL  = 12'h000;
   localparam logic [11:0] OFS_TRIG  = 12'h014;
   localparam logic [11:0] OFS_SIG   = 12'h060;
   localparam logic [11:0] OFS_READY = 12'h06C;
   localparam logic [11:0] OFS_SETEN = 12'h0A0;
   localparam logic [11:0] OFS_CLREN = 12'h0A4;
   localparam logic [11:0] OFS_DONE  = 12'h0B4;

   typedef enum logic [1:0] {
      TRIG_LVL_HI = 2'd0,
      TRIG_LVL_LO = 2'd1,
      TRIG_RISE   = 2'd2,
      TRIG_FALL   = 2'd3
   } trig_e;

endpackage

// File: rtl/pirq_line.sv
module pirq_line
   import pirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw,
   input  logic [1:0] mode,
   input  logic       soft_set,
   input  logic       claim_clr,
   output logic       pend
);
   logic smp, smp_d, edge_q, soft_q, evt;
   logic is_edge;

   assign is_edge = (mode == TRIG_RISE) || (mode == TRIG_FALL);

   always_comb begin
      if (mode == TRIG_FALL) evt = smp_d & ~smp;
      else                   evt = smp & ~smp_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp    <= 1'b0;
         smp_d  <= 1'b0;
         edge_q <= 1'b0;
         soft_q <= 1'b0;
      end else begin
         smp    <= raw;
         smp_d  <= smp;
         edge_q <= is_edge ? (evt | (edge_q & ~claim_clr)) : 1'b0;
         soft_q <= soft_set | (soft_q & ~claim_clr);
      end
   end

   always_comb begin
      if (is_edge) pend = soft_q | edge_q;
      else         pend = soft_q | (smp ^ (mode == TRIG_LVL_LO));
   end

   // R6
   edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_q) |-> $past(evt));

   // R10
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_clr && !soft_set) |=> !soft_q);

endmodule

// File: rtl/pirq_pick.sv
module pirq_pick #(
   parameter int N   = 32,
   parameter int IDW = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   cand,
   output logic           found,
   output logic [IDW-1:0] id,
   output logic [N-1:0]   grant
);
   always_comb begin
      found = 1'b0;
      id    = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            id    = IDW'(i);
         end
      end
   end

   generate
      for (genvar g = 0; g < N; g++) begin : g_grant
         if (g == 0) begin : g_first
            assign grant[g] = cand[g];
         end else begin : g_rest
            assign grant[g] = cand[g] & ~(|cand[g-1:0]);
         end
      end
   endgenerate

   // R7
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7
   grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (grant[id] && cand[id]));

endmodule

// File: rtl/pirq_if.sv
module pirq_if
   import pirq_pkg::*;
#(
   parameter int NUM_IRQ  = 32,
   parameter int NUM_CPU  = 8,
   parameter int ADDR_W   = 12,
   parameter int IPI_LINE = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [31:0]        wdata,
   input  logic               wr_en,
   input  logic               rd_en,
   output logic [31:0]        rdata,
   input  logic [NUM_IRQ-1:0] irq_lines,
   input  logic               ipi_in,
   output logic               irq_req,
   output logic               ipi_valid,
   output logic [3:0]         ipi_id,
   output logic [NUM_CPU-1:0] ipi_mask
);
   localparam int IDW    = $clog2(NUM_IRQ + 1);
   localparam int LW     = $clog2(NUM_IRQ);
   localparam int TWORDS = NUM_IRQ / 16;
   localparam int TIW    = (TWORDS > 1) ? $clog2(TWORDS) : 1;
   localparam logic [31:0] NO_IRQ = 32'(NUM_IRQ);

   if (NUM_IRQ % 16 != 0 || NUM_IRQ < 16 || NUM_IRQ > 256) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 16 between 16 and 256");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be 1 to 8");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end
   if (IPI_LINE < 0 || IPI_LINE >= NUM_IRQ) begin : g_bad_ipi
      $error("IPI_LINE out of range");
   end

   logic                 ctrl_en;
   logic [NUM_IRQ-1:0]   en, act, pend, cand, grant;
   logic [2*NUM_IRQ-1:0] modes;
   logic                 found, claim;
   logic [IDW-1:0]       pick_id;
   logic [LW-1:0]        pick_ln, num;
   logic                 num_ok;
   logic                 hit_ctrl, hit_sig, hit_ready, hit_seten, hit_clren, hit_done, hit_trig;
   logic [ADDR_W-1:0]    trig_off;
   logic [TIW-1:0]       trig_idx;
   logic [31:0]          trig_rd;
   logic                 unused_bits;

   assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
   assign hit_sig   = (addr == ADDR_W'(OFS_SIG));
   assign hit_ready = (addr == ADDR_W'(OFS_READY));
   assign hit_seten = (addr == ADDR_W'(OFS_SETEN));
   assign hit_clren = (addr == ADDR_W'(OFS_CLREN));
   assign hit_done  = (addr == ADDR_W'(OFS_DONE));
   assign trig_off  = addr - ADDR_W'(OFS_TRIG);
   assign hit_trig  = (addr >= ADDR_W'(OFS_TRIG)) &&
                      (trig_off < ADDR_W'(4 * TWORDS)) && (addr[1:0] == 2'b00);
   assign trig_idx  = trig_off[TIW+1:2];

   assign num_ok  = (wdata < NO_IRQ);
   assign num     = wdata[LW-1:0];
   assign pick_ln = pick_id[LW-1:0];
   assign unused_bits = &{1'b0, wdata, pick_id, trig_off};

   generate
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
         logic soft_i;
         if (i == IPI_LINE) begin : g_ipi
            assign soft_i = ipi_in;
         end else begin : g_plain
            assign soft_i = 1'b0;
         end
         pirq_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw       (irq_lines[i]),
            .mode      (modes[2*i +: 2]),
            .soft_set  (soft_i),
            .claim_clr (claim & grant[i]),
            .pend      (pend[i])
         );
      end
   endgenerate

   assign cand = pend & en & ~act;

   pirq_pick #(.N(NUM_IRQ), .IDW(IDW)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (cand),
      .found (found),
      .id    (pick_id),
      .grant (grant)
   );

   assign claim   = rd_en && hit_ready && ctrl_en && found;
   assign irq_req = ctrl_en && found;

   always_comb begin
      trig_rd = '0;
      for (int w = 0; w < TWORDS; w++) begin
         if (trig_idx == TIW'(w)) trig_rd = modes[w*32 +: 32];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         en      <= '0;
         act     <= '0;
      end else begin
         if (wr_en && hit_ctrl)            ctrl_en <= wdata[0];
         if (wr_en && hit_seten && num_ok) en[num] <= 1'b1;
         if (wr_en && hit_clren && num_ok) en[num] <= 1'b0;
         if (claim)                        act[pick_ln] <= 1'b1;
         if (wr_en && hit_done && num_ok)  act[num] <= 1'b0;
      end
   end

   generate
      for (genvar w = 0; w < TWORDS; w++) begin : g_trig
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                         modes[w*32 +: 32] <= '0;
            else if (wr_en && hit_trig && trig_idx == TIW'(w)) modes[w*32 +: 32] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         if (hit_ctrl)       rdata <= {31'b0, ctrl_en};
         else if (hit_trig)  rdata <= trig_rd;
         else if (hit_ready) rdata <= claim ? 32'(pick_id) : NO_IRQ;
         else                rdata <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ipi_valid <= 1'b0;
         ipi_id    <= '0;
         ipi_mask  <= '0;
      end else begin
         ipi_valid <= wr_en && hit_sig;
         if (wr_en && hit_sig) begin
            ipi_id   <= wdata[3:0];
            ipi_mask <= wdata[8 +: NUM_CPU];
         end
      end
   end

   // R9
   ipi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_valid |-> $past(wr_en && hit_sig));

   // R7
   claim_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(claim) && !$past(wr_en)) |-> act[$past(pick_ln)]);

   // R2
   off_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && hit_ready && !ctrl_en) |-> (rdata == NO_IRQ));

   // R3
   en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((en & ~$past(en)) != '0) |-> $past(wr_en && hit_seten && num_ok));

   // R8
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && hit_done && num_ok && !claim) |-> !act[$past(num)]);

endmodule

// File: tb/tb_pirq_if.sv
module tb_pirq_if;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 32;
   localparam int NC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [31:0]   rdata;
   logic [NI-1:0] irq_lines = '0;
   logic          ipi_in = 1'b0;
   logic          irq_req, ipi_valid;
   logic [3:0]    ipi_id;
   logic [NC-1:0] ipi_mask;

   int checks = 0, failures = 0, cycles = 0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   pirq_if #(.NUM_IRQ(NI), .NUM_CPU(NC), .ADDR_W(12), .IPI_LINE(15)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .irq_lines(irq_lines), .ipi_in(ipi_in),
      .irq_req(irq_req), .ipi_valid(ipi_valid), .ipi_id(ipi_id), .ipi_mask(ipi_mask));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   bit        m_s[NI], m_sp[NI], m_ep[NI], m_sft[NI], m_en[NI], m_act[NI];
   int        m_mode[NI];
   bit        m_ctrl, m_ipiv;
   int        m_ipid, m_ipmask;
   bit [31:0] m_rdata;

   function automatic bit m_pend(int i);
      if (m_mode[i] >= 2) return m_sft[i] | m_ep[i];
      return m_sft[i] | (m_s[i] ^ (m_mode[i] == 1));
   endfunction

   function automatic int m_win();
      for (int i = 0; i < NI; i++)
         if (m_pend(i) && m_en[i] && !m_act[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NI; i++) begin
            m_s[i] = 0; m_sp[i] = 0; m_ep[i] = 0; m_sft[i] = 0;
            m_en[i] = 0; m_act[i] = 0; m_mode[i] = 0;
         end
         m_ctrl = 0; m_ipiv = 0; m_ipid = 0; m_ipmask = 0; m_rdata = 0;
      end else begin
         int  w;
         bit  clm;
         bit [31:0] word;
         w   = m_win();
         clm = rd_en && addr == 12'h06C && m_ctrl && w >= 0;
         if (rd_en) begin
            if (addr == 12'h000) m_rdata = {31'b0, m_ctrl};
            else if (addr == 12'h014 || addr == 12'h018) begin
               word = 0;
               for (int k = 0; k < 16; k++)
                  word[2*k +: 2] = 2'(m_mode[(addr == 12'h018 ? 16 : 0) + k]);
               m_rdata = word;
            end else if (addr == 12'h06C) m_rdata = clm ? 32'(w) : 32'(NI);
            else m_rdata = 0;
         end
         for (int i = 0; i < NI; i++) begin
            bit ev, cl;
            cl = clm && (w == i);
            ev = (m_mode[i] == 3) ? (m_sp[i] && !m_s[i]) : (m_s[i] && !m_sp[i]);
            m_ep[i]  = (m_mode[i] >= 2) ? (ev | (m_ep[i] & !cl)) : 1'b0;
            m_sft[i] = (i == 15 && ipi_in) | (m_sft[i] & !cl);
            m_sp[i]  = m_s[i];
            m_s[i]   = irq_lines[i];
         end
         if (clm) m_act[w] = 1;
         m_ipiv = 0;
         if (wr_en) begin
            if (addr == 12'h000) m_ctrl = wdata[0];
            if (addr == 12'h014 || addr == 12'h018)
               for (int k = 0; k < 16; k++)
                  m_mode[(addr == 12'h018 ? 16 : 0) + k] = int'(wdata[2*k +: 2]);
            if (wdata < NI) begin
               if (addr == 12'h0A0) m_en[wdata] = 1;
               if (addr == 12'h0A4) m_en[wdata] = 0;
               if (addr == 12'h0B4) m_act[wdata] = 0;
            end
            if (addr == 12'h060) begin
               m_ipiv = 1; m_ipid = int'(wdata[3:0]); m_ipmask = int'(wdata[15:8]);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk({tag, " model irq_req"}, 32'(irq_req), 32'(m_ctrl && m_win() >= 0));
         chk({tag, " model rdata"}, rdata, m_rdata);
         chk("R9 model ipi_valid", 32'(ipi_valid), 32'(m_ipiv));
         if (m_ipiv) begin
            chk("R9 model ipi_id", 32'(ipi_id), 32'(m_ipid));
            chk("R9 model ipi_mask", 32'(ipi_mask), 32'(m_ipmask));
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(logic [11:0] a, logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [11:0] a, output logic [31:0] v);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   initial begin
      logic [31:0] v;
      tick(3);
      rst_n = 1'b1;
      tick();
      tag = "R1";
      chk("R1 irq_req after reset", 32'(irq_req), 0);
      bus_rd(12'h06C, v); chk("R1 ready empty", v, 32);
      bus_rd(12'h014, v); chk("R1 trig word0", v, 0);
      bus_rd(12'h018, v); chk("R1 trig word1", v, 0);

      tag = "R2";
      irq_lines[3] = 1'b1;
      bus_wr(12'h0A0, 3);
      tick(2);
      chk("R2 irq_req gated off", 32'(irq_req), 0);
      bus_rd(12'h06C, v); chk("R2 ready while off", v, 32);
      bus_wr(12'h000, 1);
      bus_rd(12'h000, v); chk("R2 control readback", v, 1);
      chk("R2 irq_req once on", 32'(irq_req), 1);

      tag = "R7";
      bus_rd(12'h06C, v); chk("R7 claim line 3", v, 3);
      chk("R7 active hides line", 32'(irq_req), 0);
      tag = "R8";
      bus_wr(12'h0B4, 3);
      chk("R8 level re-offered", 32'(irq_req), 1);
      bus_rd(12'h06C, v); chk("R8 reclaim line 3", v, 3);
      irq_lines[3] = 1'b0;
      bus_wr(12'h0B4, 3);
      bus_rd(12'h06C, v); chk("R8 none after drop", v, 32);
      bus_wr(12'h0A4, 3);

      tag = "R5";
      bus_wr(12'h0A0, 9);
      irq_lines[9] = 1'b1;
      chk("R5 not before edge", 32'(irq_req), 0);
      tick();
      chk("R5 one edge later", 32'(irq_req), 1);
      tag = "R7";
      irq_lines[5] = 1'b1;
      bus_wr(12'h0A0, 5);
      bus_rd(12'h06C, v); chk("R7 lowest first", v, 5);
      bus_rd(12'h06C, v); chk("R7 next line", v, 9);
      bus_wr(12'h0B4, 5);
      bus_wr(12'h0B4, 9);
      tag = "R3";
      bus_wr(12'h0A4, 5);
      bus_rd(12'h06C, v); chk("R3 disabled line skipped", v, 9);
      bus_wr(12'h0B4, 9);
      bus_wr(12'h0A4, 9);
      irq_lines[5] = 1'b0; irq_lines[9] = 1'b0;
      irq_lines[8] = 1'b1;
      bus_wr(12'h0A0, 40);
      tick();
      chk("R3 out-of-range ignored", 32'(irq_req), 0);
      bus_rd(12'h06C, v); chk("R3 out-of-range ready", v, 32);
      irq_lines[8] = 1'b0;

      tag = "R4";
      bus_wr(12'h018, 32'h0000_0200);
      bus_rd(12'h018, v); chk("R4 rising field line 20", v, 32'h200);
      tag = "R6";
      bus_wr(12'h0A0, 20);
      irq_lines[20] = 1'b1;
      tick();
      chk("R6 not after one edge", 32'(irq_req), 0);
      irq_lines[20] = 1'b0;
      tick();
      chk("R6 latched at second edge", 32'(irq_req), 1);
      tick();
      chk("R6 held after input low", 32'(irq_req), 1);
      bus_rd(12'h06C, v); chk("R6 claim edge line", v, 20);
      bus_wr(12'h0B4, 20);
      chk("R6 cleared by claim", 32'(irq_req), 0);

      tag = "R4";
      bus_wr(12'h018, 32'h0000_0E00);
      bus_rd(12'h018, v); chk("R4 falling field line 21", v, 32'hE00);
      tag = "R6";
      bus_wr(12'h0A0, 21);
      irq_lines[21] = 1'b1;
      tick(3);
      chk("R6 rise ignored in falling mode", 32'(irq_req), 0);
      irq_lines[21] = 1'b0;
      tick(2);
      chk("R6 falling latched", 32'(irq_req), 1);
      bus_rd(12'h06C, v); chk("R6 claim falling line", v, 21);
      bus_wr(12'h0B4, 21);
      bus_wr(12'h0A4, 20);
      bus_wr(12'h0A4, 21);

      tag = "R4";
      bus_wr(12'h014, 32'h0000_0010);
      bus_rd(12'h014, v); chk("R4 level-low field line 2", v, 32'h10);
      bus_wr(12'h0A0, 2);
      chk("R4 level-low pends at 0", 32'(irq_req), 1);
      bus_rd(12'h06C, v); chk("R4 claim level-low", v, 2);
      irq_lines[2] = 1'b1;
      tick();
      bus_wr(12'h0B4, 2);
      chk("R4 level-low idle at 1", 32'(irq_req), 0);
      bus_wr(12'h0A4, 2);
      irq_lines[2] = 1'b0;
      tick();

      tag = "R9";
      bus_wr(12'h060, 32'h0000_A50F);
      chk("R9 send pulse", 32'(ipi_valid), 1);
      chk("R9 send id", 32'(ipi_id), 32'hF);
      chk("R9 send mask", 32'(ipi_mask), 32'hA5);
      tick();
      chk("R9 pulse one cycle", 32'(ipi_valid), 0);

      tag = "R10";
      bus_wr(12'h0A0, 15);
      chk("R10 idle before pulse", 32'(irq_req), 0);
      ipi_in = 1'b1;
      tick();
      ipi_in = 1'b0;
      chk("R10 pulse pends line 15", 32'(irq_req), 1);
      tick(2);
      bus_rd(12'h06C, v); chk("R10 claim line 15", v, 15);
      bus_wr(12'h0B4, 15);
      chk("R10 cleared by claim", 32'(irq_req), 0);
      bus_rd(12'h06C, v); chk("R10 none left", v, 32);

      tick(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule